// File: doc/BRIEF.md
# SCSI Initiator Command Decoder and Interrupt Status Unit

This block sits behind the byte-wide register port of a SCSI-style initiator controller. Software writes a command byte to the command address. The block decodes the low seven bits of that byte and updates three registers: a status register, an interrupt-cause register and a sequence-step register. It drives one level-sensitive interrupt line, which always equals bit 7 of the status register.

Housekeeping commands are carried out entirely inside the block: no-op, FIFO flush, chip reset, bus reset, message accepted, pad, set-attention, enable-selection and initiator command-complete. Transfer and selection commands are not carried out here. For those, the block sends a one-cycle start pulse to an external sequencer, together with the selection variant and the DMA flag taken from bit 7 of the command byte.

Reading the interrupt-cause register has a side effect. The read returns the cause, and acknowledging it clears the cause, the interrupt and the terminal-count bit. Command codes the block does not know are ignored, except that they set a sticky flag.

Top module: `scsi_cmd_status`

## Requirements
- R1: After reset, status = 0x00, cause = 0x00, step = 0x00, configuration (address 0x8) = 0x07, identification (address 0xE) reads 0x04, the last-command register (address 0x3) reads 0x00, and `irq`, `illegal_cmd`, `xfer_go`, `sel_go` are low.
- R2: A read strobe at address A loads `reg_rdata` at the next clock edge, and the value holds until the next read. Address map: 0x3 last command byte, 0x4 status, 0x5 cause, 0x6 step, 0x8 configuration, 0xE identification. Every other address reads 0x00. Read and write strobes never coincide.
- R3: A read of address 0x5 returns the cause value held before the read. It then sets cause to 0x00, clears status bits 7 and 4, sets step to 0x04, and drops `irq`.
- R4: Command 0x02 (chip reset) restores every R1 value, including a configuration value that software has written.
- R5: Command 0x03 (bus reset) sets cause to 0x80. It sets status bit 7 (the interrupt) only when configuration bit 6 is 0.
- R6: Command 0x12 (message accepted) sets cause to 0x20 and step to 0x00, and raises the interrupt.
- R7: Command 0x18 (pad) sets status to exactly 0x10, which leaves `irq` low. It sets cause to 0x08 and step to 0x00.
- R8: Command 0x01 (flush) sets cause to 0x08 and step to 0x00, and leaves status unchanged.
- R9: Command 0x11 (command complete) sets cause to 0x08 and ORs 0x07 (message-in phase) and 0x80 (interrupt) into status.
- R10: Command 0x44 (enable selection) clears cause. Commands 0x00 (no-op) and 0x1A (set attention) change no register other than the last-command register.
- R11: Only bits 6:0 select the command. Code 0x10 pulses `xfer_go` for one cycle after the write. Codes 0x41, 0x42 and 0x43 pulse `sel_go`, with `sel_kind` set to bits 1:0 of the command byte. `dma_mode` takes bit 7 of the command byte on every command write.
- R12: Any other code leaves status, cause and step unchanged and sets `illegal_cmd`. The flag stays set until reset or chip reset.
- R13: A write to address 0x0 or 0x1 clears status bit 4 (terminal count).
- R14: `irq` equals status bit 7 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data / command byte |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt (status bit 7) |
| xfer_go | output | 1 | One-cycle transfer start pulse |
| sel_go | output | 1 | One-cycle selection start pulse |
| sel_kind | output | 2 | Selection variant (1 plain, 2 with attention, 3 with attention and stop) |
| dma_mode | output | 1 | DMA flag of the last command byte |
| illegal_cmd | output | 1 | Sticky unknown-command flag |

## Verification
The assertions assume that a read strobe and a write strobe never fall in the same cycle. The properties for the cause-clearing read and for the command effects state this as an exclusion in their antecedents. The bench drives each register access as a single-strobe cycle, so every transaction is a read or a write and never both.

The sweep covers all 256 command bytes, including both values of the DMA bit. Each byte starts from the same pre-state: the interrupt raised, a non-zero cause, and step 4.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int OPW = DW - 1;

    localparam logic [AW-1:0] A_XC_LO = 4'h0;
    localparam logic [AW-1:0] A_XC_HI = 4'h1;
    localparam logic [AW-1:0] A_CMD   = 4'h3;
    localparam logic [AW-1:0] A_STAT  = 4'h4;
    localparam logic [AW-1:0] A_CAUSE = 4'h5;
    localparam logic [AW-1:0] A_STEP  = 4'h6;
    localparam logic [AW-1:0] A_CFG   = 4'h8;
    localparam logic [AW-1:0] A_IDENT = 4'hE;

    localparam logic [DW-1:0] ST_IRQ    = 8'h80;
    localparam logic [DW-1:0] ST_TC     = 8'h10;
    localparam logic [DW-1:0] ST_MSGIN  = 8'h07;
    localparam logic [DW-1:0] CA_FDONE  = 8'h08;
    localparam logic [DW-1:0] CA_DISC   = 8'h20;
    localparam logic [DW-1:0] CA_BRST   = 8'h80;
    localparam logic [DW-1:0] CFG_INIT  = 8'h07;
    localparam logic [DW-1:0] IDENT_VAL = 8'h04;
    localparam logic [DW-1:0] STEP_ACK  = 8'h04;
    localparam int            CFG_QUIET = 6;

    typedef enum logic [OPW-1:0] {
        OP_NOP    = 7'h00,
        OP_FLUSH  = 7'h01,
        OP_CHIP   = 7'h02,
        OP_BUSRST = 7'h03,
        OP_XFER   = 7'h10,
        OP_CCS    = 7'h11,
        OP_MSGOK  = 7'h12,
        OP_PAD    = 7'h18,
        OP_ATN    = 7'h1A,
        OP_SEL    = 7'h41,
        OP_SELA   = 7'h42,
        OP_SELAS  = 7'h43,
        OP_ENSEL  = 7'h44
    } op_e;

    typedef struct packed {
        logic          set_cause;
        logic [DW-1:0] cause;
        logic          zero_step;
        logic          raise;
        logic          raise_gated;
        logic          tc_only;
        logic          or_msgin;
        logic          chip_rst;
        logic          xfer;
        logic          sel;
        logic          illegal;
    } fx_t;

    function automatic fx_t decode_op(input logic [OPW-1:0] code);
        fx_t f;
        f = '0;
        case (code)
            OP_NOP, OP_ATN: ;
            OP_FLUSH: begin f.set_cause = 1'b1; f.cause = CA_FDONE; f.zero_step = 1'b1; end
            OP_CHIP:  f.chip_rst = 1'b1;
            OP_BUSRST: begin f.set_cause = 1'b1; f.cause = CA_BRST; f.raise_gated = 1'b1; end
            OP_XFER:  f.xfer = 1'b1;
            OP_CCS:   begin f.set_cause = 1'b1; f.cause = CA_FDONE; f.or_msgin = 1'b1; f.raise = 1'b1; end
            OP_MSGOK: begin f.set_cause = 1'b1; f.cause = CA_DISC; f.zero_step = 1'b1; f.raise = 1'b1; end
            OP_PAD:   begin f.set_cause = 1'b1; f.cause = CA_FDONE; f.zero_step = 1'b1; f.tc_only = 1'b1; end
            OP_SEL, OP_SELA, OP_SELAS: f.sel = 1'b1;
            OP_ENSEL: begin f.set_cause = 1'b1; f.cause = '0; end
            default:  f.illegal = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/scmd_decoder.sv
module scmd_decoder
    import scmd_pkg::*;
(
    input  logic [DW-1:0] cmd_byte,
    output fx_t           fx
);
    always_comb fx = decode_op(cmd_byte[OPW-1:0]);
endmodule

// File: rtl/scmd_state.sv
module scmd_state
    import scmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  fx_t           fx,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] step_q,
    output logic [DW-1:0] cfg1_q,
    output logic [DW-1:0] cmd_q,
    output logic          illegal_q,
    output logic          xfer_go,
    output logic          sel_go,
    output logic [1:0]    sel_kind,
    output logic          dma_mode
);
    logic          cmd_wr;
    logic          wipe;
    logic [DW-1:0] n_status, n_cause, n_step, n_cfg1;
    logic          n_ill;

    assign cmd_wr = wr && (addr == A_CMD);
    assign wipe   = rst || (cmd_wr && fx.chip_rst);

    always_comb begin
        n_status = status_q;
        n_cause  = cause_q;
        n_step   = step_q;
        n_cfg1   = cfg1_q;
        n_ill    = illegal_q;
        if (rd && addr == A_CAUSE) begin
            n_cause  = '0;
            n_status = status_q & ~(ST_IRQ | ST_TC);
            n_step   = STEP_ACK;
        end
        if (wr && (addr == A_XC_LO || addr == A_XC_HI))
            n_status = n_status & ~ST_TC;
        if (wr && addr == A_CFG)
            n_cfg1 = wdata;
        if (cmd_wr) begin
            if (fx.set_cause) n_cause  = fx.cause;
            if (fx.zero_step) n_step   = '0;
            if (fx.tc_only)   n_status = ST_TC;
            if (fx.or_msgin)  n_status = n_status | ST_MSGIN;
            if (fx.raise)     n_status = n_status | ST_IRQ;
            if (fx.raise_gated && !cfg1_q[CFG_QUIET]) n_status = n_status | ST_IRQ;
            if (fx.illegal)   n_ill = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            status_q  <= '0;
            cause_q   <= '0;
            step_q    <= '0;
            cfg1_q    <= CFG_INIT;
            cmd_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            status_q  <= n_status;
            cause_q   <= n_cause;
            step_q    <= n_step;
            cfg1_q    <= n_cfg1;
            illegal_q <= n_ill;
            if (cmd_wr) cmd_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            xfer_go  <= 1'b0;
            sel_go   <= 1'b0;
            sel_kind <= '0;
            dma_mode <= 1'b0;
        end else begin
            xfer_go <= cmd_wr && fx.xfer;
            sel_go  <= cmd_wr && fx.sel;
            if (cmd_wr) begin
                dma_mode <= wdata[DW-1];
                if (fx.sel) sel_kind <= wdata[1:0];
            end
        end
    end
endmodule

// File: rtl/scmd_rdport.sv
module scmd_rdport
    import scmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] status_q,
    input  logic [DW-1:0] cause_q,
    input  logic [DW-1:0] step_q,
    input  logic [DW-1:0] cfg1_q,
    input  logic [DW-1:0] cmd_q,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] sel_val;

    always_comb begin
        case (addr)
            A_CMD:   sel_val = cmd_q;
            A_STAT:  sel_val = status_q;
            A_CAUSE: sel_val = cause_q;
            A_STEP:  sel_val = step_q;
            A_CFG:   sel_val = cfg1_q;
            A_IDENT: sel_val = IDENT_VAL;
            default: sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= sel_val;
    end
endmodule

// File: rtl/scsi_cmd_status.sv
module scsi_cmd_status
    import scmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          xfer_go,
    output logic          sel_go,
    output logic [1:0]    sel_kind,
    output logic          dma_mode,
    output logic          illegal_cmd
);
    fx_t           fx;
    logic [DW-1:0] status_q, cause_q, step_q, cfg1_q, cmd_q;

    scmd_decoder u_dec (
        .cmd_byte (reg_wdata),
        .fx       (fx)
    );

    scmd_state u_state (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .fx        (fx),
        .status_q  (status_q),
        .cause_q   (cause_q),
        .step_q    (step_q),
        .cfg1_q    (cfg1_q),
        .cmd_q     (cmd_q),
        .illegal_q (illegal_cmd),
        .xfer_go   (xfer_go),
        .sel_go    (sel_go),
        .sel_kind  (sel_kind),
        .dma_mode  (dma_mode)
    );

    scmd_rdport u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .status_q (status_q),
        .cause_q  (cause_q),
        .step_q   (step_q),
        .cfg1_q   (cfg1_q),
        .cmd_q    (cmd_q),
        .rdata    (reg_rdata)
    );

    assign irq = status_q[7];
endmodule

// File: rtl/scsi_cmd_status_chk.sv
module scsi_cmd_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       xfer_go,
    input logic       illegal_cmd,
    input logic [7:0] cause_q,
    input logic [7:0] step_q,
    input logic [7:0] status_q,
    input logic [7:0] cfg1_q
);
    AST_NO_RDWR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd)); // R2

    AST_CAUSE_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 4'h5) |=> (cause_q == 8'h00 && step_q == 8'h04 && !irq)); // R3

    AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_rd && reg_addr == 4'h3 && reg_wdata[6:0] == 7'h03 && cfg1_q[6] && !irq)
        |=> (!irq && cause_q == 8'h80)); // R5

    AST_MSGOK_RAISES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_rd && reg_addr == 4'h3 && reg_wdata[6:0] == 7'h12)
        |=> (irq && cause_q == 8'h20 && step_q == 8'h00)); // R6

    AST_PAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_rd && reg_addr == 4'h3 && reg_wdata[6:0] == 7'h18)
        |=> (!irq && status_q == 8'h10 && cause_q == 8'h08)); // R7

    AST_XFER_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> $past(reg_wr && reg_addr == 4'h3 && reg_wdata[6:0] == 7'h10)); // R11

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (illegal_cmd && !(reg_wr && reg_addr == 4'h3 && reg_wdata[6:0] == 7'h02)) |=> illegal_cmd); // R12
endmodule

bind scsi_cmd_status scsi_cmd_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .xfer_go     (xfer_go),
    .illegal_cmd (illegal_cmd),
    .cause_q     (cause_q),
    .step_q      (step_q),
    .status_q    (status_q),
    .cfg1_q      (cfg1_q)
);

// File: tb/scsi_cmd_status_bench.sv
`timescale 1ns/1ps
module scsi_cmd_status_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, xfer_go, sel_go, dma_mode, illegal_cmd;
    logic [1:0] sel_kind;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scsi_cmd_status u_scsi_cmd_status (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .xfer_go(xfer_go), .sel_go(sel_go), .sel_kind(sel_kind),
        .dma_mode(dma_mode), .illegal_cmd(illegal_cmd)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic do_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    function automatic string req_of(input logic [6:0] op);
        case (op)
            7'h00, 7'h1A, 7'h44: return "R10";
            7'h01: return "R8";
            7'h02: return "R4";
            7'h03: return "R5";
            7'h10, 7'h41, 7'h42, 7'h43: return "R11";
            7'h11: return "R9";
            7'h12: return "R6";
            7'h18: return "R7";
            default: return "R12";
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_rst();
        // R1: reset state
        chk("R1", "irq", {7'b0, irq}, 8'h00);
        chk("R1", "illegal", {7'b0, illegal_cmd}, 8'h00);
        chk("R1", "rdata", reg_rdata, 8'h00);
        do_rd(4'h4, v); chk("R1", "status", v, 8'h00);
        do_rd(4'h5, v); chk("R1", "cause", v, 8'h00);
        do_rd(4'h8, v); chk("R1", "cfg", v, 8'h07);
        do_rd(4'hE, v); chk("R1", "ident", v, 8'h04);
        do_rd(4'h3, v); chk("R1", "lastcmd", v, 8'h00);
        // R2: unmapped address and hold between reads
        do_rd(4'h9, v); chk("R2", "unmapped", v, 8'h00);
        do_rd(4'hE, v);
        @(negedge clk); @(negedge clk);
        chk("R2", "hold", reg_rdata, 8'h04);

        // R5: suppression by configuration bit 6
        do_wr(4'h8, 8'h47);
        do_wr(4'h3, 8'h03);
        chk("R5", "irq quiet", {7'b0, irq}, 8'h00);
        do_rd(4'h5, v); chk("R5", "cause quiet", v, 8'h80);
        // R4: chip reset restores configuration
        do_wr(4'h3, 8'h02);
        do_rd(4'h8, v); chk("R4", "cfg restore", v, 8'h07);

        // R13: count-register writes clear terminal count
        for (int a = 0; a < 2; a++) begin
            do_wr(4'h3, 8'h18);
            do_rd(4'h4, v); chk("R13", "tc set", v, 8'h10);
            do_wr(a[3:0], 8'h55);
            do_rd(4'h4, v); chk("R13", "tc clear", v, 8'h00);
        end

        // R12: sticky until chip reset
        do_wr(4'h3, 8'h05);
        do_wr(4'h3, 8'h00);
        chk("R12", "sticky", {7'b0, illegal_cmd}, 8'h01);
        do_wr(4'h3, 8'h82);
        chk("R12", "cleared by chip reset", {7'b0, illegal_cmd}, 8'h00);

        // Sweep of every command byte from a fixed pre-state
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb, e_st, e_ca, e_sp, e_cmd;
            logic       e_ill, e_x, e_s;
            logic [6:0] op;
            string      rq;
            cb = c[7:0]; op = cb[6:0]; rq = req_of(op);
            e_st = 8'h80; e_ca = 8'h80; e_sp = 8'h04; e_cmd = cb;
            e_ill = 1'b0; e_x = 1'b0; e_s = 1'b0;
            case (op)
                7'h00, 7'h1A: ;
                7'h01: begin e_ca = 8'h08; e_sp = 8'h00; end
                7'h02: begin e_st = 8'h00; e_ca = 8'h00; e_sp = 8'h00; e_cmd = 8'h00; end
                7'h03: ;
                7'h10: e_x = 1'b1;
                7'h11: begin e_ca = 8'h08; e_st = 8'h87; end
                7'h12: begin e_ca = 8'h20; e_sp = 8'h00; end
                7'h18: begin e_st = 8'h10; e_ca = 8'h08; e_sp = 8'h00; end
                7'h41, 7'h42, 7'h43: e_s = 1'b1;
                7'h44: e_ca = 8'h00;
                default: e_ill = 1'b1;
            endcase
            do_rst();
            do_wr(4'h3, 8'h18);
            do_rd(4'h5, v);
            do_wr(4'h3, 8'h03);
            do_wr(4'h3, cb);
            chk(rq, "xfer pulse", {7'b0, xfer_go}, {7'b0, e_x});
            chk(rq, "sel pulse", {7'b0, sel_go}, {7'b0, e_s});
            if (e_s) chk("R11", "sel kind", {6'b0, sel_kind}, {6'b0, cb[1:0]});
            if (op != 7'h02) chk("R11", "dma bit", {7'b0, dma_mode}, {7'b0, cb[7]});
            chk(rq, "illegal", {7'b0, illegal_cmd}, {7'b0, e_ill});
            chk("R14", "irq vs status", {7'b0, irq}, {7'b0, e_st[7]});
            @(negedge clk);
            chk("R11", "pulse width", {6'b0, xfer_go, sel_go}, 8'h00);
            do_rd(4'h4, v); chk(rq, "status", v, e_st);
            do_rd(4'h6, v); chk(rq, "step", v, e_sp);
            do_rd(4'h3, v); chk(rq, "lastcmd", v, e_cmd);
            do_rd(4'h5, v); chk(rq, "cause", v, e_ca);
            // R3: acknowledge side effects
            chk("R3", "irq after ack", {7'b0, irq}, 8'h00);
            do_rd(4'h6, v); chk("R3", "step after ack", v, 8'h04);
            do_rd(4'h4, v); chk("R3", "status after ack", v, e_st & 8'h6F);
            do_rd(4'h5, v); chk("R3", "cause after ack", v, 8'h00);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule